// File: doc/BRIEF.md
# Receive Frame Length Validator

This block sits on the receive byte stream of an Ethernet MAC, after the preamble and start-of-frame delimiter have been removed. Every byte that belongs to a frame is counted, and the block notices an 802.1Q tag by the value of the two octets that follow the addresses. It forwards the frame's bytes unchanged until the frame exceeds the size cap for its kind. After that it stops forwarding and discards the rest of the frame until the end marker arrives.

One cycle after the last byte of a frame, the block raises a one-cycle status word. The word carries the forwarded length, a tag flag, an oversize flag, an undersize flag and a bad mark. The bad mark also takes in a frame-check error that the upstream CRC logic supplies with the final byte. A configuration input selects large-frame mode, which raises the acceptance limit for all frames.

Top module: `rx_len_check`

## Requirements
- R1: A frame runs from the byte marked `in_sof` to the byte marked `in_eof`, both included. `stat_len` reports the number of bytes forwarded for it.
- R2: `stat_valid` is high for exactly one cycle. That cycle is the one right after the clock edge that takes in the frame's end byte. It stays low at all other times.
- R3: In normal mode, an untagged frame longer than 1518 bytes sets `stat_over`. Only its first 1519 bytes are forwarded, and `stat_len` is 1519.
- R4: A frame is tagged when byte offset 12 holds 0x81 and offset 13 holds 0x00 (offsets from 0). Such a frame sets `stat_vlan`. In normal mode its limit is 1522 bytes and its truncation point is 1523 bytes.
- R5: In large-frame mode (`jumbo_en`=1), frames of up to 2048 bytes pass without `stat_over`. Longer frames set `stat_over`, only 2048 bytes are forwarded, and `stat_len` is 2048. This holds whether or not the frame is tagged.
- R6: A frame whose reported length is below 64 sets `stat_under`, whether it is tagged or not.
- R7: `stat_bad` equals `stat_over` OR `stat_under` OR the `fcs_err` value presented with the end byte.
- R8: Valid bytes that arrive outside a frame (no `in_sof` while idle) produce no output byte and no status word.
- R9: `out_valid` is high exactly for the forwarded bytes of a frame. While it is high, `out_data` equals `in_data`. Idle cycles inside a frame (`in_valid`=0) forward nothing.
- R10: While in reset and right after it, `stat_valid` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jumbo_en | input | 1 | Large-frame mode select |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| fcs_err | input | 1 | Frame-check error, sampled with the end byte |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | Forwarded byte is the frame's first |
| stat_valid | output | 1 | Status word present (one cycle) |
| stat_len | output | 12 | Forwarded length of the frame |
| stat_vlan | output | 1 | Frame carried a tag |
| stat_over | output | 1 | Frame exceeded its limit |
| stat_under | output | 1 | Frame shorter than 64 bytes |
| stat_bad | output | 1 | Frame is erroneous |

## Verification
The hardest case to reach is the set of boundary lengths for each combination of tag and mode, because there the limit and the truncation point differ by one byte. In normal mode the over byte is still forwarded, and in large-frame mode it is not. The bench sweeps lengths on both sides of 1518, 1522 and 2048, for tagged and untagged frames in both modes. It also uses short frames that end before or right at the tag offsets. Short frames get idle gaps inside them, so that counting across stalls is exercised.

// File: rtl/rx_len_check.sv
module rx_len_check #(
  parameter int LW        = 12,
  parameter int MIN_LEN   = 64,
  parameter int STD_MAX   = 1518,
  parameter int TAG_BYTES = 4,
  parameter int JUMBO_MAX = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          jumbo_en,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          fcs_err,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_sof,
  output logic          stat_valid,
  output logic [LW-1:0] stat_len,
  output logic          stat_vlan,
  output logic          stat_over,
  output logic          stat_under,
  output logic          stat_bad
);
  localparam logic [LW-1:0] MIN_L  = LW'(MIN_LEN);
  localparam logic [LW-1:0] STD_L  = LW'(STD_MAX);
  localparam logic [LW-1:0] TAG_L  = LW'(STD_MAX + TAG_BYTES);
  localparam logic [LW-1:0] JMB_L  = LW'(JUMBO_MAX);
  localparam logic [LW-1:0] OFS_HI = LW'(12);
  localparam logic [LW-1:0] OFS_LO = LW'(13);

  logic          in_frm, vlan, b12_hit, over;
  logic [LW-1:0] cnt;

  wire          take     = in_valid & (in_sof | in_frm);
  wire [LW-1:0] idx      = in_sof ? '0 : cnt;
  wire          vlan_cur = in_sof ? 1'b0 : vlan;
  wire [LW-1:0] max_ok   = jumbo_en ? JMB_L : (vlan_cur ? TAG_L : STD_L);
  wire [LW-1:0] cap      = jumbo_en ? JMB_L : max_ok + LW'(1);
  wire          acc      = take & (idx < cap);
  wire [LW-1:0] nlen     = acc ? idx + LW'(1) : idx;
  wire          over_n   = (in_sof ? 1'b0 : over) | (idx >= max_ok);
  wire          hit12_n  = (idx == OFS_HI) & (in_data == 8'h81);
  wire          vlan_n   = vlan_cur | ((idx == OFS_LO) & b12_hit & (in_data == 8'h00));

  assign out_valid = acc;
  assign out_data  = in_data;
  assign out_sof   = acc & in_sof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frm     <= 1'b0;
      cnt        <= '0;
      vlan       <= 1'b0;
      b12_hit    <= 1'b0;
      over       <= 1'b0;
      stat_valid <= 1'b0;
      stat_len   <= '0;
      stat_vlan  <= 1'b0;
      stat_over  <= 1'b0;
      stat_under <= 1'b0;
      stat_bad   <= 1'b0;
    end else begin
      stat_valid <= take & in_eof;
      if (take) begin
        in_frm <= ~in_eof;
        cnt    <= nlen;
        over   <= over_n;
        vlan   <= vlan_n;
        if (idx == OFS_HI) b12_hit <= hit12_n;
        if (in_eof) begin
          stat_len   <= nlen;
          stat_vlan  <= vlan_n;
          stat_over  <= over_n;
          stat_under <= nlen < MIN_L;
          stat_bad   <= over_n | (nlen < MIN_L) | fcs_err;
        end
      end
    end
  end

  a_r2_status_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(in_valid & in_eof & (in_sof | in_frm)));
  a_r7_flags_make_bad: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid & (stat_over | stat_under) |-> stat_bad);
  a_r5_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> stat_len <= JMB_L);
  a_r3_over_long: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid & stat_over |-> stat_len > STD_L);
  a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frm & !in_sof |-> !out_valid);
  a_r6_short_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid & (stat_len < MIN_L) |-> stat_under);
endmodule

// File: tb/rx_len_check_tb.sv
`timescale 1ns/1ps
module rx_len_check_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic jumbo_en = 0, in_valid = 0, in_sof = 0, in_eof = 0, fcs_err = 0;
  logic [7:0] in_data = 0;
  logic out_valid, out_sof, stat_valid, stat_vlan, stat_over, stat_under, stat_bad;
  logic [7:0] out_data;
  logic [11:0] stat_len;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_len_check dut_i (
    .clk(clk), .rst_n(rst_n), .jumbo_en(jumbo_en), .in_valid(in_valid),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .fcs_err(fcs_err),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .stat_valid(stat_valid), .stat_len(stat_len), .stat_vlan(stat_vlan),
    .stat_over(stat_over), .stat_under(stat_under), .stat_bad(stat_bad));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 0; in_sof = 0; in_eof = 0; fcs_err = 0;
  endtask

  task automatic send(input int len, input bit tag, input bit jm, input bit fcs, input bit gaps);
    int seen = 0, data_bad = 0, gap_bad = 0;
    bit tg = tag && len >= 14;
    int mx = jm ? 2048 : (tg ? 1522 : 1518);
    int cp = jm ? 2048 : mx + 1;
    int el = len < cp ? len : cp;
    bit eo = len > mx;
    bit eu = el < 64;
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk); idle();
        #1 if (out_valid) gap_bad++;
      end
      @(negedge clk);
      jumbo_en = jm; in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
      fcs_err = fcs && (i == len - 1);
      in_data = (tag && i == 12) ? 8'h81 : (tag && i == 13) ? 8'h00 : 8'(i * 7 + 3);
      #1 if (out_valid) begin
        seen++;
        if (out_data != in_data) data_bad++;
        if (out_sof != (i == 0)) data_bad++;
      end
    end
    @(negedge clk); idle();
    #1;
    chk(stat_valid, "R2 status pulse", int'(stat_valid), 1);
    chk(stat_len == 12'(el), "R1/R3/R5 length", int'(stat_len), el);
    chk(seen == el, "R9 forwarded bytes (R3 R4 R5 truncation)", seen, el);
    chk(data_bad == 0 && gap_bad == 0, "R9 data/gap", data_bad + gap_bad, 0);
    chk(stat_over == eo, "R3/R4/R5 over", int'(stat_over), int'(eo));
    chk(stat_under == eu, "R6 under", int'(stat_under), int'(eu));
    chk(stat_vlan == tg, "R4 tag", int'(stat_vlan), int'(tg));
    chk(stat_bad == (eo | eu | fcs), "R7 bad", int'(stat_bad), int'(eo | eu | fcs));
    @(negedge clk); #1;
    chk(!stat_valid, "R2 single cycle", int'(stat_valid), 0);
  endtask

  initial begin
    #1_000_000;
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens[17] = '{1, 13, 14, 63, 64, 65, 1517, 1518, 1519, 1520, 1522, 1523, 1524, 2047, 2048, 2049, 2060};
    repeat (3) @(negedge clk);
    #1;
    chk(!stat_valid && !out_valid, "R10 reset", int'(stat_valid | out_valid), 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!stat_valid && !out_valid, "R10 after reset", int'(stat_valid | out_valid), 0);
    for (int jm = 0; jm < 2; jm++)
      for (int tg = 0; tg < 2; tg++)
        foreach (lens[k]) send(lens[k], tg[0], jm[0], 1'b0, lens[k] < 100);
    send(70, 1'b0, 1'b0, 1'b1, 1'b0);
    send(1600, 1'b1, 1'b1, 1'b1, 1'b0);
    send(40, 1'b1, 1'b0, 1'b1, 1'b1);
    // R8: stray bytes without a start marker
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_valid = 1; in_sof = 0; in_eof = (i == 4); in_data = 8'(i);
      #1 chk(!out_valid, "R8 stray byte", int'(out_valid), 0);
    end
    @(negedge clk); idle();
    #1 chk(!stat_valid, "R8 no status", int'(stat_valid), 0);
    send(64, 1'b0, 1'b0, 1'b0, 1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule